// File: doc/BRIEF.md
# Level-1 Latency Pipeline and Triggered Event Store

This block sits in a front-end digitizer right after deserialization. Every clock it takes one 12-bit sample for each of four channels. Six samples make one beam crossing. All samples go into a circular delay line. The trigger decision arrives a programmable number of samples later, and the delay line lets that decision pick out the samples that caused it. When a Level-1 accept arrives, the block copies a fixed-length window of delayed samples into one of eight event slots. A downstream reader drains the slots one word at a time, each event starting with a header word.

The delay line is a ring addressed by a free-running write pointer. The read address is the write pointer minus the programmed delay, taken modulo the ring depth, so delays up to 240 samples (40 crossings) fit in a 256-entry ring. Alongside the event path, each channel compares every sample against seven ascending thresholds. It emits a 3-bit trigger primitive that names the highest threshold the sample exceeds.

Top module: `l1_latency_buffer`

## Requirements
- R1: For a delay setting D from 1 to 240, sample k of a captured event (k counted from 0) equals the sample that was presented D clock edges before the edge that is k edges after the edge registering the accept.
- R2: The window length N of an event is cfgWindow limited to the range 1 to 16. A setting of 0 gives 1, a setting above 16 gives 16, and the length is fixed per event when the accept is taken.
- R3: Each event is read out as one header word followed by 4·N sample words. The samples come channel by channel, and within a channel they come in time order. A sample word carries the sample in bits 11:0 with bits 15:12 zero. rdLast is high only on the final word.
- R4: Up to 8 completed events are held. busy is high exactly while 8 completed events are waiting.
- R5: An accept that arrives while busy is high, or while an earlier event's window is still being captured, is dropped: ovfCount increments by one, no event is stored and the event number does not advance.
- R6: While rdValid is high and rdReady is low, rdValid and rdData hold steady. A word is consumed on a clock edge where both are high. After the last word of an event is consumed, its slot is free on the next cycle.
- R7: The header word holds a 16-bit event number. The number is 0 for the first accepted trigger after reset and increases by one per accepted trigger. Events are read out oldest first.
- R8: primCode for channel c sits in bits 3c+2:3c. It is registered, and its value is the largest level index plus one among the levels whose threshold the sample strictly exceeds, or 0 if it exceeds none. Threshold level l (0 = lowest) of channel c is cfgThresh bits (7c+l)·12 + 11 down to (7c+l)·12.
- R9: During reset, busy, rdValid, rdLast, ovfCount and primCode are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleIn | input | 48 | One 12-bit sample per channel; channel c in bits 12c+11:12c |
| l1Accept | input | 1 | Level-1 accept strobe, one cycle per trigger |
| cfgDelay | input | 8 | Trigger latency in samples (1 to 240) |
| cfgWindow | input | 5 | Samples captured per channel per event |
| cfgThresh | input | 336 | Seven ascending 12-bit thresholds per channel |
| rdReady | input | 1 | Reader accepts the current word |
| rdValid | output | 1 | A readout word is present |
| rdData | output | 16 | Header (event number) or zero-extended sample |
| rdLast | output | 1 | Final word of the current event |
| busy | output | 1 | All event slots are occupied |
| ovfCount | output | 16 | Number of accepts dropped |
| primCode | output | 12 | 3-bit trigger primitive per channel |

## Verification
Each sample carries its channel number in the top two bits and a running time tag in the low ten bits. This exposes an off-by-one delay, a wrong window start and a swapped channel order in a single compare. The delay and window pairs span the smallest and largest delays and both clamp cases of the window setting. A burst of triggers with the reader stalled fills every slot, which separates slot counting, the busy edge and the dropping of a ninth trigger. Two accepts on adjacent cycles isolate the drop during capture. Fixed samples placed just below, exactly on and just above thresholds separate a strict compare from an inclusive one.

// File: rtl/l1p_pkg.sv
`timescale 1ns/1ps
package l1p_pkg;
  localparam int NUM_CH      = 4;
  localparam int SAMPLE_W    = 12;
  localparam int NUM_LEVELS  = 7;
  localparam int CODE_W      = $clog2(NUM_LEVELS + 1);
  localparam int RING_DEPTH  = 256;
  localparam int RING_AW     = $clog2(RING_DEPTH);
  localparam int WIN_MAX     = 16;
  localparam int WIN_IW      = $clog2(WIN_MAX);
  localparam int WIN_LW      = $clog2(WIN_MAX + 1);
  localparam int NUM_SLOTS   = 8;
  localparam int SLOT_W      = $clog2(NUM_SLOTS);
  localparam int FILL_W      = $clog2(NUM_SLOTS + 1);
  localparam int CH_W        = $clog2(NUM_CH);
  localparam int EVT_W       = 16;
  localparam int WORD_W      = 16;
  localparam int STORE_AW    = SLOT_W + WIN_IW;
  localparam int STORE_DEPTH = NUM_SLOTS * WIN_MAX;
  localparam int ROW_W       = NUM_CH * SAMPLE_W;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic                capWrite;
    logic [SLOT_W-1:0]   capSlot;
    logic [WIN_IW-1:0]   capIdx;
    logic                rdHeader;
    logic [SLOT_W-1:0]   rdSlot;
    logic [CH_W-1:0]     rdCh;
    logic [WIN_IW-1:0]   rdIdx;
    logic [EVT_W-1:0]    rdEvt;
  } strobe_t;
endpackage

// File: rtl/l1p_prim_enc.sv
`timescale 1ns/1ps
module l1p_prim_enc
  import l1p_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [SAMPLE_W-1:0]            sample,
  input  logic [NUM_LEVELS*SAMPLE_W-1:0] thresh,
  output logic [CODE_W-1:0]              code
);
  logic [SAMPLE_W-1:0] lvl [NUM_LEVELS];
  logic [CODE_W-1:0]   codeNext;

  always_comb begin
    for (int l = 0; l < NUM_LEVELS; l++) lvl[l] = thresh[l*SAMPLE_W +: SAMPLE_W];
  end

  // highest level strictly exceeded wins
  always_comb begin
    codeNext = '0;
    for (int l = 0; l < NUM_LEVELS; l++)
      if (sample > lvl[l]) codeNext = CODE_W'(l + 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) code <= '0;
    else        code <= codeNext;
  end

  // R8: a nonzero code implies the named level was exceeded
  p_code_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(thresh) && code != '0) |->
      ($past(sample) > lvl[code - CODE_W'(1)]));

  // R8: the next level up was not exceeded
  p_code_ceil_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(thresh) && code != CODE_W'(NUM_LEVELS)) |->
      ($past(sample) <= lvl[code]));
endmodule

// File: rtl/l1p_ctrl.sv
`timescale 1ns/1ps
module l1p_ctrl
  import l1p_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l1Accept,
  input  logic [WIN_LW-1:0] cfgWindow,
  input  logic              rdReady,
  output strobe_t           strb,
  output logic              rdValid,
  output logic              rdLast,
  output logic              busy,
  output logic [EVT_W-1:0]  ovfCount
);
  logic              capActive;
  logic [WIN_IW-1:0] capCnt;
  logic [WIN_LW-1:0] capLen;
  logic [WIN_LW-1:0] winEff;
  logic [SLOT_W-1:0] wSlot, rSlot;
  logic [FILL_W-1:0] filled;
  logic [EVT_W-1:0]  evtNum, ovfCnt;
  logic [EVT_W-1:0]  slotEvt [NUM_SLOTS];
  logic [WIN_LW-1:0] slotLen [NUM_SLOTS];
  logic              rdActive, rdHdr;
  logic [CH_W-1:0]   rdCh;
  logic [WIN_IW-1:0] rdIdx;
  logic [WIN_LW-1:0] rdLen;
  logic              acceptOk, capDone, rdFire, rdDone, rdStart, idxEnd, lastWord;

  // window length clamp
  always_comb begin
    if (cfgWindow == '0)                     winEff = WIN_LW'(1);
    else if (cfgWindow > WIN_LW'(WIN_MAX))   winEff = WIN_LW'(WIN_MAX);
    else                                     winEff = cfgWindow;
  end

  assign acceptOk = l1Accept && !capActive && (filled != FILL_W'(NUM_SLOTS));
  assign capDone  = (acceptOk && winEff == WIN_LW'(1)) ||
                    (capActive && (WIN_LW'(capCnt) == capLen - WIN_LW'(1)));

  assign rdLen    = slotLen[rSlot];
  assign idxEnd   = (WIN_LW'(rdIdx) == rdLen - WIN_LW'(1));
  assign lastWord = rdActive && !rdHdr && (rdCh == CH_W'(NUM_CH - 1)) && idxEnd;
  assign rdFire   = rdActive && rdReady;
  assign rdDone   = rdFire && lastWord;
  assign rdStart  = !rdActive && (filled != '0);

  // capture sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capActive <= 1'b0;
      capCnt    <= '0;
      capLen    <= WIN_LW'(1);
      wSlot     <= '0;
      evtNum    <= '0;
      ovfCnt    <= '0;
    end else begin
      if (acceptOk) begin
        evtNum <= evtNum + EVT_W'(1);
        capLen <= winEff;
        if (winEff != WIN_LW'(1)) begin
          capActive <= 1'b1;
          capCnt    <= WIN_IW'(1);
        end
      end else if (capActive) begin
        capCnt <= capCnt + WIN_IW'(1);
        if (capDone) capActive <= 1'b0;
      end
      if (capDone) wSlot <= wSlot + SLOT_W'(1);
      if (l1Accept && !acceptOk) ovfCnt <= ovfCnt + EVT_W'(1);
    end
  end

  // per-slot descriptors
  always_ff @(posedge clk) begin
    if (acceptOk) begin
      slotEvt[wSlot] <= evtNum;
      slotLen[wSlot] <= winEff;
    end
  end

  // occupancy
  always_ff @(posedge clk) begin
    if (!rst_n) filled <= '0;
    else if (capDone && !rdDone) filled <= filled + FILL_W'(1);
    else if (!capDone && rdDone) filled <= filled - FILL_W'(1);
  end

  // readout sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdActive <= 1'b0;
      rdHdr    <= 1'b0;
      rdCh     <= '0;
      rdIdx    <= '0;
      rSlot    <= '0;
    end else if (rdStart) begin
      rdActive <= 1'b1;
      rdHdr    <= 1'b1;
      rdCh     <= '0;
      rdIdx    <= '0;
    end else if (rdFire) begin
      if (rdHdr) begin
        rdHdr <= 1'b0;
      end else if (idxEnd) begin
        rdIdx <= '0;
        if (rdCh == CH_W'(NUM_CH - 1)) begin
          rdActive <= 1'b0;
          rSlot    <= rSlot + SLOT_W'(1);
        end else begin
          rdCh <= rdCh + CH_W'(1);
        end
      end else begin
        rdIdx <= rdIdx + WIN_IW'(1);
      end
    end
  end

  always_comb begin
    strb.capWrite = acceptOk || capActive;
    strb.capSlot  = wSlot;
    strb.capIdx   = capActive ? capCnt : '0;
    strb.rdHeader = rdHdr;
    strb.rdSlot   = rSlot;
    strb.rdCh     = rdCh;
    strb.rdIdx    = rdIdx;
    strb.rdEvt    = slotEvt[rSlot];
  end

  assign rdValid  = rdActive;
  assign rdLast   = lastWord;
  assign busy     = (filled == FILL_W'(NUM_SLOTS));
  assign ovfCount = ovfCnt;

  p_slot_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    filled <= FILL_W'(NUM_SLOTS));

  p_ovf_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (l1Accept && busy) |=> ((ovfCount - $past(ovfCount)) == EVT_W'(1)));

  p_busy_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (l1Accept && busy) |=> $stable(evtNum));

  p_slot_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdLast && rdReady) |=> !busy);
endmodule

// File: rtl/l1p_datapath.sv
`timescale 1ns/1ps
module l1p_datapath
  import l1p_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [ROW_W-1:0]                      sampleIn,
  input  logic [RING_AW-1:0]                    cfgDelay,
  input  logic [NUM_CH*NUM_LEVELS*SAMPLE_W-1:0] cfgThresh,
  input  strobe_t                               strb,
  output logic [WORD_W-1:0]                     rdData,
  output logic [NUM_CH*CODE_W-1:0]              primCode
);
  logic [ROW_W-1:0]    ring  [RING_DEPTH];
  logic [ROW_W-1:0]    store [STORE_DEPTH];
  logic [RING_AW-1:0]  wrPtr, tapAddr;
  logic [STORE_AW-1:0] capAddr, outAddr;
  logic [ROW_W-1:0]    outRow;
  logic [SAMPLE_W-1:0] outSample;

  // circular latency buffer
  always_ff @(posedge clk) begin
    if (!rst_n) wrPtr <= '0;
    else        wrPtr <= wrPtr + RING_AW'(1);
  end

  always_ff @(posedge clk) ring[wrPtr] <= sampleIn;

  assign tapAddr = wrPtr - cfgDelay;

  // event slots: one row of all channels per window position
  assign capAddr = {strb.capSlot, strb.capIdx};
  always_ff @(posedge clk) begin
    if (strb.capWrite) store[capAddr] <= ring[tapAddr];
  end

  assign outAddr   = {strb.rdSlot, strb.rdIdx};
  assign outRow    = store[outAddr];
  assign outSample = outRow[strb.rdCh*SAMPLE_W +: SAMPLE_W];
  assign rdData    = strb.rdHeader ? strb.rdEvt
                                   : {{(WORD_W-SAMPLE_W){1'b0}}, outSample};

  // trigger primitives
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_prim
    l1p_prim_enc u_enc (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (sampleIn[ch*SAMPLE_W +: SAMPLE_W]),
      .thresh (cfgThresh[ch*NUM_LEVELS*SAMPLE_W +: NUM_LEVELS*SAMPLE_W]),
      .code   (primCode[ch*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/l1_latency_buffer.sv
`timescale 1ns/1ps
module l1_latency_buffer
  import l1p_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [ROW_W-1:0]                      sampleIn,
  input  logic                                  l1Accept,
  input  logic [RING_AW-1:0]                    cfgDelay,
  input  logic [WIN_LW-1:0]                     cfgWindow,
  input  logic [NUM_CH*NUM_LEVELS*SAMPLE_W-1:0] cfgThresh,
  input  logic                                  rdReady,
  output logic                                  rdValid,
  output logic [WORD_W-1:0]                     rdData,
  output logic                                  rdLast,
  output logic                                  busy,
  output logic [EVT_W-1:0]                      ovfCount,
  output logic [NUM_CH*CODE_W-1:0]              primCode
);
  strobe_t strb;

  l1p_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .l1Accept (l1Accept),
    .cfgWindow(cfgWindow),
    .rdReady  (rdReady),
    .strb     (strb),
    .rdValid  (rdValid),
    .rdLast   (rdLast),
    .busy     (busy),
    .ovfCount (ovfCount)
  );

  l1p_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sampleIn (sampleIn),
    .cfgDelay (cfgDelay),
    .cfgThresh(cfgThresh),
    .strb     (strb),
    .rdData   (rdData),
    .primCode (primCode)
  );

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData)));
endmodule

// File: tb/l1_latency_buffer_tb_top.sv
`timescale 1ns/1ps
module l1_latency_buffer_tb_top;
  import l1p_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ROW_W-1:0] sampleIn;
  logic l1Accept = 1'b0;
  logic [RING_AW-1:0] cfgDelay = '0;
  logic [WIN_LW-1:0] cfgWindow = '0;
  logic [NUM_CH*NUM_LEVELS*SAMPLE_W-1:0] cfgThresh = '0;
  logic rdReady = 1'b0;
  logic rdValid, rdLast, busy;
  logic [WORD_W-1:0] rdData;
  logic [EVT_W-1:0] ovfCount;
  logic [NUM_CH*CODE_W-1:0] primCode;

  int checks = 0;
  int fails = 0;
  int edgeNo = 0;
  int wdog = 0;
  logic useFixed = 1'b0;
  logic [ROW_W-1:0] fixedVal = '0;

  always #2.5 clk = ~clk;

  l1_latency_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .sampleIn(sampleIn), .l1Accept(l1Accept),
    .cfgDelay(cfgDelay), .cfgWindow(cfgWindow), .cfgThresh(cfgThresh),
    .rdReady(rdReady), .rdValid(rdValid), .rdData(rdData), .rdLast(rdLast),
    .busy(busy), .ovfCount(ovfCount), .primCode(primCode)
  );

  // sample value = {channel, time tag}
  function automatic int expSample(int t, int c);
    return (c << 10) | (t & 1023);
  endfunction

  function automatic logic [ROW_W-1:0] patRow(int t);
    logic [ROW_W-1:0] w;
    for (int c = 0; c < NUM_CH; c++) w[c*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(expSample(t, c));
    return w;
  endfunction

  always @(posedge clk) edgeNo <= edgeNo + 1;
  always @(negedge clk) sampleIn <= useFixed ? fixedVal : patRow(edgeNo);

  always @(posedge clk) begin
    wdog++;
    if (wdog > 100000) begin
      fails++;
      $display("FAIL R9 watchdog: cycles %0d expected below %0d", wdog, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic fireAccept(output int tag);
    @(negedge clk);
    l1Accept = 1'b1;
    tag = edgeNo;
    @(negedge clk);
    l1Accept = 1'b0;
  endtask

  task automatic readEvent(input string req, input int expEvt, input int tag,
                           input int dly, input int len);
    int words [80];
    int n = 0;
    int badAct = 0, badExp = 0, badIdx = -1;
    logic seenLast;
    @(negedge clk);
    for (int i = 0; i < 600; i++) begin
      if (rdValid) break;
      @(negedge clk);
    end
    for (int i = 0; i < 80; i++) begin
      if (!rdValid) break;
      words[n] = int'(rdData);
      n++;
      seenLast = rdLast;
      rdReady = 1'b1;
      @(negedge clk);
      if (seenLast) break;
    end
    rdReady = 1'b0;
    chk({req, " R2 R3 word count"}, n, 1 + NUM_CH * len);
    if (n > 0) chk({req, " R7 header event number"}, words[0], expEvt & 16'hFFFF);
    for (int c = 0; c < NUM_CH; c++)
      for (int k = 0; k < len; k++) begin
        int idx = 1 + c * len + k;
        int e = expSample(tag + k - dly, c);
        if (idx < n && badIdx < 0 && words[idx] != e) begin
          badIdx = idx; badAct = words[idx]; badExp = e;
        end
      end
    chk($sformatf("%s R1 R3 sample word %0d", req, badIdx), badAct, badExp);
  endtask

  // {delay, window setting}
  localparam int NV = 7;
  localparam logic [15:0] VECS [NV] = '{
    {8'd40,  8'd4},  {8'd240, 8'd16}, {8'd1,   8'd1},  {8'd6, 8'd8},
    {8'd100, 8'd0},  {8'd17,  8'd20}, {8'd239, 8'd3}
  };

  initial begin
    int expEvt = 0;
    int tag;
    int tags [NUM_SLOTS];
    int len;
    int ovfBase;
    int d0, d1;

    for (int c = 0; c < NUM_CH; c++)
      for (int l = 0; l < NUM_LEVELS; l++)
        cfgThresh[(c*NUM_LEVELS + l)*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(100 * (l + 1));
    cfgDelay = 8'd40;
    cfgWindow = 5'd4;

    repeat (4) @(negedge clk);
    chk("R9 reset busy", int'(busy), 0);
    chk("R9 reset rdValid", int'(rdValid), 0);
    chk("R9 reset rdLast", int'(rdLast), 0);
    chk("R9 reset ovfCount", int'(ovfCount), 0);
    chk("R9 reset primCode", int'(primCode), 0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);

    // table of delay/window vectors (R1 R2 R3 R7)
    for (int v = 0; v < NV; v++) begin
      cfgDelay  = VECS[v][15:8];
      cfgWindow = VECS[v][4:0];
      len = (VECS[v][4:0] == 0) ? 1 : (VECS[v][4:0] > WIN_MAX) ? WIN_MAX : int'(VECS[v][4:0]);
      fireAccept(tag);
      readEvent($sformatf("vec%0d", v), expEvt, tag, int'(VECS[v][15:8]), len);
      expEvt++;
    end
    chk("R5 no drops in table", int'(ovfCount), 0);

    // fill all slots with the reader stalled (R4 R5 R6 R7)
    cfgDelay = 8'd10;
    cfgWindow = 5'd2;
    ovfBase = int'(ovfCount);
    for (int i = 0; i < NUM_SLOTS; i++) begin
      fireAccept(tags[i]);
      repeat (3) @(negedge clk);
      if (i == NUM_SLOTS - 2) chk("R4 busy low with 7 held", int'(busy), 0);
    end
    chk("R4 busy high with 8 held", int'(busy), 1);
    @(negedge clk); d0 = int'(rdData);
    @(negedge clk); d1 = int'(rdData);
    chk("R6 word held while stalled", d1, d0);
    chk("R7 oldest header first", d0, expEvt);
    fireAccept(tag);
    @(negedge clk);
    chk("R5 drop when busy counted", int'(ovfCount), ovfBase + 1);
    chk("R5 busy still high", int'(busy), 1);
    for (int i = 0; i < NUM_SLOTS; i++) begin
      readEvent("drain R7", expEvt + i, tags[i], 10, 2);
      if (i == 0) chk("R6 slot freed after last word", int'(busy), 0);
    end
    expEvt += NUM_SLOTS;
    repeat (20) @(negedge clk);
    chk("R5 dropped trigger not stored", int'(rdValid), 0);

    // accept during an active capture window (R5)
    cfgDelay = 8'd50;
    cfgWindow = 5'd16;
    @(negedge clk);
    l1Accept = 1'b1;
    tag = edgeNo;
    @(negedge clk);
    @(negedge clk);
    l1Accept = 1'b0;
    chk("R5 drop during capture counted", int'(ovfCount), ovfBase + 2);
    readEvent("overlap R5", expEvt, tag, 50, 16);
    expEvt++;
    repeat (40) @(negedge clk);
    chk("R5 second accept not stored", int'(rdValid), 0);

    // threshold encoder (R8): levels at 100..700
    useFixed = 1'b1;
    fixedVal = {12'd450, 12'd101, 12'd100, 12'd50};
    repeat (3) @(negedge clk);
    chk("R8 ch0 below all", int'(primCode[2:0]), 0);
    chk("R8 ch1 equal to lowest", int'(primCode[5:3]), 0);
    chk("R8 ch2 just above lowest", int'(primCode[8:6]), 1);
    chk("R8 ch3 mid ladder", int'(primCode[11:9]), 4);
    fixedVal = {12'd4095, 12'd701, 12'd700, 12'd699};
    repeat (3) @(negedge clk);
    chk("R8 ch0 under top", int'(primCode[2:0]), 6);
    chk("R8 ch1 equal to top", int'(primCode[5:3]), 6);
    chk("R8 ch2 just above top", int'(primCode[8:6]), 7);
    chk("R8 ch3 full scale", int'(primCode[11:9]), 7);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule